// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Sequencer

This block turns a qualified three-level PWM command into two gate enable bits, one for the high-side switch and one for the low-side switch of a synchronous buck power stage. It never lets the two switches conduct together. Before a switch turns on, the block waits until the opposite gate is reported discharged by its sense comparator. It then waits a further fixed dead delay, counted in clock cycles. The two comparator inputs are asynchronous. Each passes through a synchronizer before the sequencer uses it.

The stage runs only when the supply-good input is high and the active-low disable input is high. An input left open is expected to settle low, so an open disable input also keeps the stage off. The shutdown command turns both switches off. A skip input gates the low-side switch with no clock in the path, so a controller can run diode emulation one cycle at a time. When skip has already removed the low-side drive and PWM goes high, the high-side switch does not wait for a sense event. It goes straight into its dead delay.

Top module: `gate_seq`

## Requirements
- R1: While `pwr_good` is 0, `hs_on` and `ls_on` are both 0 in the same cycle, whatever the other inputs are. From the next clock edge on, the sequencer is idle.
- R2: While `drv_en` is 0, both outputs are 0 in the same cycle and the sequencer is idle from the next edge on. An open `drv_en` pin is treated as 0.
- R3: A shutdown command (`pwm_cmd` = 2'b10 or 2'b11) drives both outputs to 0 one clock edge after it is applied.
- R4: With the stage enabled and `pwm_cmd` = 2'b01 (HIGH) held, the outputs settle to `hs_on`=1 and `ls_on`=0. This holds for either value of `skip_n`.
- R5: With the stage enabled and `pwm_cmd` = 2'b00 (LOW) held, the outputs settle to `ls_on`=1 when `skip_n`=1. They settle to both 0 when `skip_n`=0.
- R6: On a LOW-to-HIGH change while the low side is driven, `ls_on` falls at the first edge. `hs_on` stays 0 while `ls_gate_low` is 0. Once `ls_gate_low` rises, `hs_on` rises exactly SYNC_STAGES+1+DEAD_HS_CYC edges later.
- R7: On a HIGH-to-LOW change with `skip_n`=1, `hs_on` falls at the first edge. `ls_on` stays 0 while `hs_gate_low` is 0. Once `hs_gate_low` rises, `ls_on` rises exactly SYNC_STAGES+1+DEAD_LS_CYC edges later.
- R8: While the sequencer holds the low side, a change on `skip_n` reaches `ls_on` within the same cycle, with no clock edge in between.
- R9: Suppose `pwm_cmd` goes HIGH while the low side is held but masked by `skip_n`=0. Then `hs_on` rises DEAD_HS_CYC+1 edges later, even if `ls_gate_low` stays 0.
- R10: `hs_on` and `ls_on` are never 1 in the same cycle.
- R11: While `rst_n` is 0, both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pwr_good | input | 1 | Supply above its lockout threshold |
| drv_en | input | 1 | Active-low disable input: 1 lets the stage switch |
| pwm_cmd | input | 2 | Qualified command: 00 LOW, 01 HIGH, 1x shutdown |
| skip_n | input | 1 | 1 allows the low-side switch, 0 masks it |
| ls_gate_low | input | 1 | Asynchronous comparator: low-side gate below its trip level |
| hs_gate_low | input | 1 | Asynchronous comparator: high-side gate-to-switch-node voltage below its trip level |
| hs_on | output | 1 | High-side gate enable |
| ls_on | output | 1 | Low-side gate enable |

## Verification
Two functions can act in the same cycle. The skip mask changes `ls_on` with no clock, while the sequencer starts a low-to-high handover on a clock edge. The bench provokes this in a directed test: `skip_n` is dropped while the low side is held, and `pwm_cmd` goes HIGH with the low-side sense held inactive. The check is that the high side still comes on after exactly the short dead delay. The same pairing is also reached at random. A bench plant model feeds the gate outputs back into both sense inputs with a delay, and every cycle is judged against the no-overlap rule. Each settled window is judged against the enable and skip truth table.

// File: rtl/gs_pkg.sv
package gs_pkg;

  // Qualified PWM command encoding (bit 1 set means shutdown)
  localparam logic [1:0] CMD_LOW  = 2'b00;
  localparam logic [1:0] CMD_HIGH = 2'b01;

  typedef enum logic [2:0] {
    S_OFF = 3'd0,  // both switches off
    S_HS  = 3'd1,  // high side conducting
    S_LS  = 3'd2,  // low side held (output still masked by skip)
    S_WLS = 3'd3,  // waiting for the low-side gate to be sensed low
    S_DHS = 3'd4,  // dead delay before the high side
    S_WHS = 3'd5,  // waiting for the high-side gate to be sensed low
    S_DLS = 3'd6   // dead delay before the low side
  } seq_state_t;

  typedef enum logic [1:0] {
    T_NONE = 2'd0,
    T_HS   = 2'd1,
    T_LS   = 2'd2
  } target_t;

endpackage

// File: rtl/gs_sync.sv
module gs_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);

  logic [WIDTH-1:0] chain_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain_q[i] <= '0;
    end else begin
      chain_q[0] <= d_async;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
    end
  end

  assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/gs_dead_timer.sv
module gs_dead_timer #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          run,
  output logic          done
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = load | (run & (cnt_q != '0));

  always_comb begin
    cnt_d = cnt_q;
    if (load)       cnt_d = load_val;
    else if (run)   cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/gs_gate_mask.sv
module gs_gate_mask (
  input  logic en,
  input  logic skip_n,
  input  logic hs_req,
  input  logic ls_req,
  output logic hs_on,
  output logic ls_on
);

  // Combinational masking: disable and skip reach the gates without a clock
  assign hs_on = en & hs_req;
  assign ls_on = en & skip_n & ls_req & ~hs_req;

endmodule

// File: rtl/gate_seq.sv
module gate_seq
  import gs_pkg::*;
#(
  parameter int DEAD_HS_CYC = 2,
  parameter int DEAD_LS_CYC = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_good,
  input  logic       drv_en,
  input  logic [1:0] pwm_cmd,
  input  logic       skip_n,
  input  logic       ls_gate_low,
  input  logic       hs_gate_low,
  output logic       hs_on,
  output logic       ls_on
);

  localparam int DEAD_MAX = (DEAD_HS_CYC > DEAD_LS_CYC) ? DEAD_HS_CYC : DEAD_LS_CYC;
  localparam int CW       = $clog2(DEAD_MAX + 1);

  logic       en;
  logic [1:0] sense_s;
  logic       ls_low_s, hs_low_s;
  target_t    tgt;
  seq_state_t st_q, st_d;
  logic       tmr_load, tmr_run, tmr_done;
  logic [CW-1:0] tmr_val;

  assign en = pwr_good & drv_en;

  gs_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async ({hs_gate_low, ls_gate_low}),
    .q_sync  (sense_s)
  );

  assign ls_low_s = sense_s[0];
  assign hs_low_s = sense_s[1];

  // Command decode: skip only masks the low-side output, it does not retarget
  always_comb begin
    if (pwm_cmd == CMD_HIGH)     tgt = T_HS;
    else if (pwm_cmd == CMD_LOW) tgt = T_LS;
    else                         tgt = T_NONE;
  end

  // Next-state logic
  always_comb begin
    st_d = st_q;
    if (!en || tgt == T_NONE) begin
      st_d = S_OFF;
    end else if (tgt == T_HS) begin
      case (st_q)
        S_HS:    st_d = S_HS;
        S_DHS:   st_d = tmr_done ? S_HS : S_DHS;
        S_WLS:   st_d = ls_low_s ? S_DHS : S_WLS;
        S_LS:    st_d = skip_n ? S_WLS : S_DHS;
        default: st_d = S_WLS;
      endcase
    end else begin
      case (st_q)
        S_LS:    st_d = S_LS;
        S_DLS:   st_d = tmr_done ? S_LS : S_DLS;
        S_WHS:   st_d = hs_low_s ? S_DLS : S_WHS;
        default: st_d = S_WHS;
      endcase
    end
  end

  // State register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= S_OFF;
    else        st_q <= st_d;
  end

  // Shared dead-delay timer: the two dead states are mutually exclusive
  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (st_d == S_DHS && st_q != S_DHS) begin
      tmr_load = 1'b1;
      tmr_val  = CW'(DEAD_HS_CYC - 1);
    end else if (st_d == S_DLS && st_q != S_DLS) begin
      tmr_load = 1'b1;
      tmr_val  = CW'(DEAD_LS_CYC - 1);
    end
  end

  assign tmr_run = (st_q == S_DHS) || (st_q == S_DLS);

  gs_dead_timer #(.CW(CW)) u_dead (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .run      (tmr_run),
    .done     (tmr_done)
  );

  gs_gate_mask u_mask (
    .en     (en),
    .skip_n (skip_n),
    .hs_req (st_q == S_HS),
    .ls_req (st_q == S_LS),
    .hs_on  (hs_on),
    .ls_on  (ls_on)
  );

endmodule

// File: rtl/gate_seq_chk.sv
module gate_seq_chk
  import gs_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       pwr_good,
  input logic       drv_en,
  input logic [1:0] pwm_cmd,
  input logic       skip_n,
  input logic       hs_on,
  input logic       ls_on,
  input seq_state_t st_q,
  input logic       ls_low_s
);

  p_pgood_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> (st_q == S_OFF));

  p_disable_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_en |=> (st_q == S_OFF));

  p_shutdown_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_cmd[1] |=> (!hs_on && !ls_on));

  p_hs_waits_sense_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_WLS && !ls_low_s) |=> !hs_on);

  p_hs_break_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_on) |-> !$past(ls_on));

  p_ls_break_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ls_on) && $past(skip_n)) |-> !$past(hs_on));

  p_no_overlap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_on && ls_on));

endmodule

bind gate_seq gate_seq_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pwr_good (pwr_good),
  .drv_en   (drv_en),
  .pwm_cmd  (pwm_cmd),
  .skip_n   (skip_n),
  .hs_on    (hs_on),
  .ls_on    (ls_on),
  .st_q     (st_q),
  .ls_low_s (ls_low_s)
);

// File: tb/gate_seq_bench.sv
module gate_seq_bench;

  localparam int DHS = 2;
  localparam int DLS = 3;
  localparam int SYN = 2;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       pwr_good, drv_en, skip_n, ls_gate_low, hs_gate_low;
  logic [1:0] pwm_cmd;
  logic       hs_on, ls_on;

  int errors = 0;
  int checks = 0;
  bit plant_on = 1'b0;
  bit finished = 1'b0;
  logic [2:0] lhist = '0, hhist = '0;

  always #4 clk = ~clk;

  gate_seq #(.DEAD_HS_CYC(DHS), .DEAD_LS_CYC(DLS), .SYNC_STAGES(SYN)) u_gate_seq (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .drv_en(drv_en),
    .pwm_cmd(pwm_cmd), .skip_n(skip_n), .ls_gate_low(ls_gate_low),
    .hs_gate_low(hs_gate_low), .hs_on(hs_on), .ls_on(ls_on)
  );

  function automatic logic exp_hs(logic pg, logic de, logic [1:0] c, logic sk);
    return pg & de & (c == 2'b01);
  endfunction

  function automatic logic exp_ls(logic pg, logic de, logic [1:0] c, logic sk);
    return pg & de & (c == 2'b00) & sk;
  endfunction

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {hs,ls} actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // One clock: wait for the falling edge; the plant model and overlap check act there
  task automatic tick();
    @(negedge clk);
    checks++;
    if (hs_on && ls_on) begin
      errors++;
      $display("FAIL R10: {hs,ls} actual=11 expected=not 11 at %0t", $time);
    end
    if (plant_on) begin
      lhist = {lhist[1:0], ls_on};
      hhist = {hhist[1:0], hs_on};
      ls_gate_low = ~|lhist;
      hs_gate_low = ~|hhist;
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; pwr_good = 1'b1; drv_en = 1'b1; pwm_cmd = 2'b01;
    skip_n = 1'b1; ls_gate_low = 1'b1; hs_gate_low = 1'b1;
    ticks(3);
    chk("R11 reset", {hs_on, ls_on}, 2'b00);
    rst_n = 1'b1;

    // R5: LOW with skip high settles to low side
    pwm_cmd = 2'b00; ls_gate_low = 1'b0; hs_gate_low = 1'b1;
    ticks(20);
    chk("R5 low skip=1", {hs_on, ls_on}, 2'b01);

    // R6: LOW->HIGH handover
    pwm_cmd = 2'b01;
    tick();
    chk("R6 ls off first", {hs_on, ls_on}, 2'b00);
    ticks(8);
    chk("R6 hs waits sense", {hs_on, ls_on}, 2'b00);
    ls_gate_low = 1'b1;
    ticks(SYN + DHS);
    chk("R6 before dead end", {hs_on, ls_on}, 2'b00);
    tick();
    chk("R6 hs on at dead end", {hs_on, ls_on}, 2'b10);

    // R4: HIGH with skip low still high side
    skip_n = 1'b0;
    ticks(3);
    chk("R4 high skip=0", {hs_on, ls_on}, 2'b10);
    skip_n = 1'b1;
    ticks(3);
    chk("R4 high skip=1", {hs_on, ls_on}, 2'b10);

    // R7: HIGH->LOW handover
    hs_gate_low = 1'b0; ls_gate_low = 1'b1;
    tick();
    pwm_cmd = 2'b00;
    tick();
    chk("R7 hs off first", {hs_on, ls_on}, 2'b00);
    ticks(6);
    chk("R7 ls waits sense", {hs_on, ls_on}, 2'b00);
    hs_gate_low = 1'b1;
    ticks(SYN + DLS);
    chk("R7 before dead end", {hs_on, ls_on}, 2'b00);
    tick();
    chk("R7 ls on at dead end", {hs_on, ls_on}, 2'b01);

    // R8: skip reaches the low side within the cycle
    #1 skip_n = 1'b0;
    #1 chk("R8 skip low masks", {hs_on, ls_on}, 2'b00);
    skip_n = 1'b1;
    #1 chk("R8 skip high restores", {hs_on, ls_on}, 2'b01);
    tick();

    // R5: LOW with skip low: both off
    skip_n = 1'b0;
    ticks(2);
    chk("R5 low skip=0", {hs_on, ls_on}, 2'b00);

    // R9: masked low side, HIGH goes straight to dead delay, no sense event
    ls_gate_low = 1'b0;
    pwm_cmd = 2'b01;
    ticks(DHS);
    chk("R9 before dead end", {hs_on, ls_on}, 2'b00);
    tick();
    chk("R9 hs on without sense", {hs_on, ls_on}, 2'b10);
    skip_n = 1'b1; ls_gate_low = 1'b1;

    // R1 / R2: immediate hold-off
    #1 pwr_good = 1'b0;
    #1 chk("R1 supply low", {hs_on, ls_on}, 2'b00);
    ticks(2);
    chk("R1 supply low held", {hs_on, ls_on}, 2'b00);
    pwr_good = 1'b1;
    ticks(4);
    chk("R4 restart high", {hs_on, ls_on}, 2'b10);
    #1 drv_en = 1'b0;
    #1 chk("R2 disable low", {hs_on, ls_on}, 2'b00);
    ticks(2);
    chk("R2 disable held", {hs_on, ls_on}, 2'b00);
    drv_en = 1'b1;
    ticks(4);

    // R3: shutdown command
    pwm_cmd = 2'b10;
    tick();
    chk("R3 shutdown", {hs_on, ls_on}, 2'b00);
    pwm_cmd = 2'b11;
    ticks(3);
    chk("R3 shutdown alt code", {hs_on, ls_on}, 2'b00);

    // Random phase with a delayed gate-sense plant
    plant_on = 1'b1;
    for (int seg = 0; seg < 400; seg++) begin
      pwm_cmd  = 2'($urandom_range(0, 3));
      skip_n   = 1'($urandom_range(0, 1));
      pwr_good = ($urandom_range(0, 15) != 0);
      drv_en   = ($urandom_range(0, 15) != 0);
      if (seg % 10 == 9) begin
        ticks(30);
        chk("R4/R5 settled random", {hs_on, ls_on},
            {exp_hs(pwr_good, drv_en, pwm_cmd, skip_n),
             exp_ls(pwr_good, drv_en, pwm_cmd, skip_n)});
      end else begin
        ticks($urandom_range(1, 12));
      end
    end

    finish_run();
  end

endmodule